// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block gathers 32 external interrupt request lines and presents them to a processor through a small word-indexed register bus with an address, a write strobe, write data and combinational read data. Every line first passes through a two-flop synchroniser. After that it is handled as either a level or an edge source. Software picks the active sense per line: high or rising, or low or falling. Edge events are latched into a status register. Software clears them by writing ones to that register. A level source's status bit simply tracks its active level.

An enable register gates the status bits into a masked view. A routing register splits the enabled sources between two registered outputs, a non-critical one and a critical one. The block also presents the number of the highest-numbered enabled pending source, with a valid flag, for an interrupt entry routine.

Every per-source register uses reversed bit order: source n sits at bit 31-n, so source 0 is the most significant bit. Offsets are: status 0x0, enable 0x2, routing 0x3, sense 0x4, mode 0x5, masked status 0x6. Every other offset reads as zero and ignores writes. This includes 0x7 and 0x8, which are kept free for vector logic that is not part of this block.

Top module: `intc32`

## Requirements
- R1: After reset, enable, routing, mode and status read 0. Sense reads 0xFFFFFFFF. Both interrupt outputs are low, and pend_valid is 0.
- R2: Source n (src_in[n]) occupies bit 31-n of status, enable, routing, sense, mode and masked status.
- R3: For a source whose mode bit is 0 (level), the status bit equals the active level of the input. Active means high when the sense bit is 1 and low when it is 0. The value is visible after the third rising clock edge following an input change. Writing a 1 to that status bit does not clear it while the input stays active.
- R4: For a source whose mode bit is 1 (edge), the status bit is set by a synchronised rising edge when the sense bit is 1, or by a falling edge when it is 0. The bit holds until cleared. A new edge in the same cycle as a clear leaves the bit set.
- R5: A write to offset 0x0 clears each edge-mode status bit whose write-data bit is 1 and leaves those with 0 unchanged. Writing 0xFFFFFFFF clears every edge-mode source.
- R6: Offset 0x6 reads status AND enable.
- R7: irq_noncrit is high one clock after some masked status bit with routing bit 0 is set. irq_crit does the same for routing bit 1. Both are registered ORs.
- R8: pend_valid is 1 exactly when masked status is nonzero. pend_idx then gives the highest-numbered source whose masked status bit is set, which is the least significant set bit.
- R9: Offsets 0x1, 0x6 and 0x7 to 0xF ignore writes, and offsets 0x1 and 0x7 to 0xF read zero.
- R10: Enable, routing, sense and mode read back the value last written. A write takes effect at the clock edge where reg_we is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Interrupt request lines, source n on bit n |
| reg_addr | input | 4 | Register word offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_noncrit | output | 1 | Non-critical interrupt request |
| irq_crit | output | 1 | Critical interrupt request |
| pend_valid | output | 1 | An enabled source is pending |
| pend_idx | output | 5 | Highest-numbered enabled pending source |

## Verification
An input change reaches status, masked status and the pending index after the third rising edge: two synchroniser stages plus the capture stage. The interrupt outputs follow one edge later. A register write is readable right after the edge that takes it. The bench drives inputs just after a rising edge and changes the read address just after a falling edge. It compares the design against a behavioural model on every falling edge. It also places each directed check after exactly the edge counts given above, so both the latency and the values are checked.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned SRC_N  = 32;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [3:0] {
    OFS_STAT  = 4'h0,
    OFS_EN    = 4'h2,
    OFS_CRIT  = 4'h3,
    OFS_POL   = 4'h4,
    OFS_TRIG  = 4'h5,
    OFS_MSTAT = 4'h6
  } ofs_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES];

  generate
    for (genvar st = 0; st < STAGES; st++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[st] <= '0;
        else if (st == 0) chain[st] <= d;
        else chain[st] <= chain[(st == 0) ? 0 : st-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] s,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat,
  output logic [N-1:0] act,
  output logic [N-1:0] edge_ev
);
  logic [N-1:0] s_prev;
  logic [N-1:0] act_prev;

  function automatic logic [N-1:0] active_of(input logic [N-1:0] v, input logic [N-1:0] p);
    return ~(v ^ p);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= '0;
    else s_prev <= s;
  end

  assign act      = active_of(s, pol);
  assign act_prev = active_of(s_prev, pol);
  assign edge_ev  = act & ~act_prev;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat[i] <= 1'b0;
        else if (trig[i]) stat[i] <= (stat[i] & ~clr[i]) | edge_ev[i];
        else stat[i] <= act[i];
      end
    end
  endgenerate
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [N-1:0]  wdata,
  input  logic [N-1:0]  stat,
  input  logic [N-1:0]  masked,
  output logic [N-1:0]  en,
  output logic [N-1:0]  crit,
  output logic [N-1:0]  pol,
  output logic [N-1:0]  trig,
  output logic [N-1:0]  clr,
  output logic [N-1:0]  rdata
);
  function automatic logic hit(input logic [AW-1:0] a, input ofs_e o);
    return a == AW'(o);
  endfunction

  assign clr = (we && hit(addr, OFS_STAT)) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      crit <= '0;
      pol  <= '1;
      trig <= '0;
    end else if (we) begin
      if (hit(addr, OFS_EN))   en   <= wdata;
      if (hit(addr, OFS_CRIT)) crit <= wdata;
      if (hit(addr, OFS_POL))  pol  <= wdata;
      if (hit(addr, OFS_TRIG)) trig <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit(addr, OFS_STAT))  rdata = stat;
    if (hit(addr, OFS_EN))    rdata = en;
    if (hit(addr, OFS_CRIT))  rdata = crit;
    if (hit(addr, OFS_POL))   rdata = pol;
    if (hit(addr, OFS_TRIG))  rdata = trig;
    if (hit(addr, OFS_MSTAT)) rdata = masked;
  end
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  stat,
  input  logic [N-1:0]  en,
  input  logic [N-1:0]  crit,
  output logic [N-1:0]  masked,
  output logic          irq_noncrit,
  output logic          irq_crit,
  output logic          pend_valid,
  output logic [IW-1:0] pend_idx
);
  function automatic logic [IW:0] top_source(input logic [N-1:0] m);
    logic [IW:0] r;
    r = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (m[i]) r = {1'b1, IW'(N-1-i)};
    end
    return r;
  endfunction

  logic [IW:0] pick;

  assign masked     = stat & en;
  assign pick       = top_source(masked);
  assign pend_valid = pick[IW];
  assign pend_idx   = pick[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_noncrit <= 1'b0;
      irq_crit    <= 1'b0;
    end else begin
      irq_noncrit <= |(masked & ~crit);
      irq_crit    <= |(masked & crit);
    end
  end
endmodule

// File: rtl/intc32.sv
module intc32
  import intc_pkg::*;
#(
  parameter int SRC_N_P     = SRC_N,
  parameter int ADDR_W_P    = ADDR_W,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(SRC_N_P)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_N_P-1:0]  src_in,
  input  logic [ADDR_W_P-1:0] reg_addr,
  input  logic                reg_we,
  input  logic [SRC_N_P-1:0]  reg_wdata,
  output logic [SRC_N_P-1:0]  reg_rdata,
  output logic                irq_noncrit,
  output logic                irq_crit,
  output logic                pend_valid,
  output logic [IDX_W-1:0]    pend_idx
);
  logic [SRC_N_P-1:0] src_bits;
  logic [SRC_N_P-1:0] sync_bits;
  logic [SRC_N_P-1:0] stat, lvl_act, edge_ev;
  logic [SRC_N_P-1:0] en, crit, pol, trig, clr_mask, masked;

  generate
    for (genvar n = 0; n < SRC_N_P; n++) begin : g_map
      assign src_bits[SRC_N_P-1-n] = src_in[n];
    end
  endgenerate

  intc_sync #(.N(SRC_N_P), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(src_bits), .q(sync_bits)
  );

  intc_capture #(.N(SRC_N_P)) u_capture (
    .clk(clk), .rst_n(rst_n), .s(sync_bits), .pol(pol), .trig(trig),
    .clr(clr_mask), .stat(stat), .act(lvl_act), .edge_ev(edge_ev)
  );

  intc_regs #(.N(SRC_N_P), .AW(ADDR_W_P)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .stat(stat), .masked(masked), .en(en), .crit(crit), .pol(pol),
    .trig(trig), .clr(clr_mask), .rdata(reg_rdata)
  );

  intc_route #(.N(SRC_N_P), .IW(IDX_W)) u_route (
    .clk(clk), .rst_n(rst_n), .stat(stat), .en(en), .crit(crit),
    .masked(masked), .irq_noncrit(irq_noncrit), .irq_crit(irq_crit),
    .pend_valid(pend_valid), .pend_idx(pend_idx)
  );
endmodule

// File: rtl/intc32_chk.sv
module intc32_chk #(
  parameter int N  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic [N-1:0]  reg_rdata,
  input logic [N-1:0]  stat,
  input logic [N-1:0]  lvl_act,
  input logic [N-1:0]  edge_ev,
  input logic [N-1:0]  trig,
  input logic [N-1:0]  clr_mask,
  input logic [N-1:0]  masked,
  input logic [N-1:0]  en,
  input logic [N-1:0]  crit,
  input logic          irq_noncrit,
  input logic          irq_crit,
  input logic          pend_valid
);
  // R1: quiet state on leaving reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_crit && !irq_noncrit && stat == '0));

  // R3: level-mode status tracks the active level one edge later
  p_level_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~$past(trig)) == ($past(lvl_act) & ~$past(trig)));

  // R4: edge-mode bits hold without an event or a clear
  p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat ^ $past(stat)) & $past(trig) & ~$past(clr_mask) & ~$past(edge_ev)) == '0);

  // R5: a clear without a new edge drops the bit
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_mask) & $past(trig) & ~$past(edge_ev) & stat) == '0);

  // R6: masked view
  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    masked == (stat & en));

  // R7: registered routing
  p_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_crit == |($past(masked) & $past(crit))) &&
    (irq_noncrit == |($past(masked) & ~$past(crit))));

  // R8: pending flag
  p_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid == (masked != '0));

  // R9: unused offset reads zero
  p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(7)) |-> (reg_rdata == '0));
endmodule

bind intc32 intc32_chk #(.N(SRC_N_P), .AW(ADDR_W_P)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .stat(stat), .lvl_act(lvl_act), .edge_ev(edge_ev), .trig(trig),
  .clr_mask(clr_mask), .masked(masked), .en(en), .crit(crit),
  .irq_noncrit(irq_noncrit), .irq_crit(irq_crit), .pend_valid(pend_valid)
);

// File: tb/intc32_bench.sv
`timescale 1ns/1ps
module intc32_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_noncrit, irq_crit, pend_valid;
  logic [4:0]  pend_idx;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  intc32 u_intc32 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_noncrit(irq_noncrit), .irq_crit(irq_crit),
    .pend_valid(pend_valid), .pend_idx(pend_idx)
  );

  // behavioural reference, register bits in reversed order (source n at bit 31-n)
  logic [31:0] m1, m2, mp, ms, men, mcr, mpol, mtr;
  bit mnc, mc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; mp = 0; ms = 0; men = 0; mcr = 0; mpol = '1; mtr = 0;
      mnc = 0; mc = 0;
    end else begin
      logic [31:0] nxt, clr, raw;
      mnc = |(ms & men & ~mcr);
      mc  = |(ms & men & mcr);
      clr = (reg_we && reg_addr == 0) ? reg_wdata : 32'h0;
      for (int n = 0; n < 32; n++) begin
        int b;
        bit s, sp, p, act, evt;
        b = 31 - n;
        s = m2[b]; sp = mp[b]; p = mpol[b];
        act = p ? s : !s;
        evt = p ? (s && !sp) : (!s && sp);
        if (mtr[b]) nxt[b] = (ms[b] && !clr[b]) || evt;
        else nxt[b] = act;
        raw[b] = src_in[n];
      end
      if (reg_we) begin
        case (reg_addr)
          4'd2: men  = reg_wdata;
          4'd3: mcr  = reg_wdata;
          4'd4: mpol = reg_wdata;
          4'd5: mtr  = reg_wdata;
          default: ;
        endcase
      end
      ms = nxt; mp = m2; m2 = m1; m1 = raw;
    end
  end

  function automatic logic [31:0] mread(input logic [3:0] a);
    case (a)
      4'd0: return ms;
      4'd2: return men;
      4'd3: return mcr;
      4'd4: return mpol;
      4'd5: return mtr;
      4'd6: return ms & men;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [5:0] mpend();
    for (int n = 31; n >= 0; n--)
      if ((ms & men) & (32'h1 << (31 - n))) return {1'b1, 5'(n)};
    return 6'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      string t;
      case (reg_addr)
        4'd0: t = "R3 model status";
        4'd6: t = "R6 model masked";
        4'd2, 4'd3, 4'd4, 4'd5: t = "R10 model readback";
        default: t = "R9 model unused";
      endcase
      chk(t, reg_rdata, mread(reg_addr));
      chk("R7 model irq", {30'h0, irq_crit, irq_noncrit}, {30'h0, mc, mnc});
      chk("R8 model pend", {26'h0, pend_valid, pend_idx}, {26'h0, mpend()});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic setsrc(input int n, input bit v);
    @(posedge clk); #1;
    src_in[n] = v;
  endtask

  task automatic settle(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    cmp_on = 1;
    // R1 reset state
    rd(2, v); chk("R1 enable", v, 32'h0);
    rd(3, v); chk("R1 routing", v, 32'h0);
    rd(5, v); chk("R1 mode", v, 32'h0);
    rd(4, v); chk("R1 sense", v, 32'hFFFF_FFFF);
    rd(0, v); chk("R1 status", v, 32'h0);
    chk("R1 outputs", {29'h0, irq_crit, irq_noncrit, pend_valid}, 32'h0);
    // R10 readback
    wr(2, 32'h1234_5678); rd(2, v); chk("R10 enable", v, 32'h1234_5678);
    wr(2, 32'h0);
    // R3 level, source 3 at bit 28 (R2)
    setsrc(3, 1); repeat (3) @(posedge clk);
    rd(0, v); chk("R2 R3 level set", v, 32'h1000_0000);
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R3 level not cleared", v, 32'h1000_0000);
    setsrc(3, 0); repeat (3) @(posedge clk);
    rd(0, v); chk("R3 level drop", v, 32'h0);
    // R4 rising edge, source 5 at bit 26
    wr(5, 32'h0400_0000);
    setsrc(5, 1); setsrc(5, 0); repeat (3) @(posedge clk);
    rd(0, v); chk("R4 rising latch", v, 32'h0400_0000);
    settle(5); rd(0, v); chk("R4 hold", v, 32'h0400_0000);
    wr(0, 32'h0); rd(0, v); chk("R5 zero keeps", v, 32'h0400_0000);
    wr(0, 32'h0400_0000); rd(0, v); chk("R5 one clears", v, 32'h0);
    // R4 falling edge, source 6 at bit 25
    setsrc(6, 1); repeat (3) @(posedge clk);
    rd(0, v); chk("R3 level src6", v, 32'h0200_0000);
    wr(5, 32'h0600_0000); wr(4, 32'hFDFF_FFFF); wr(0, 32'h0200_0000);
    rd(0, v); chk("R5 clear src6", v, 32'h0);
    setsrc(6, 0); repeat (3) @(posedge clk);
    rd(0, v); chk("R4 falling latch", v, 32'h0200_0000);
    // R7 R8 routing and pending
    setsrc(5, 1); setsrc(5, 0); repeat (3) @(posedge clk);
    wr(3, 32'h0400_0000); wr(2, 32'h0600_0000);
    settle(1);
    chk("R7 both outputs", {30'h0, irq_crit, irq_noncrit}, 32'h3);
    chk("R8 pend highest", {26'h0, pend_valid, pend_idx}, {26'h0, 1'b1, 5'd6});
    rd(6, v); chk("R6 masked", v, 32'h0600_0000);
    wr(0, 32'h0200_0000); settle(1);
    chk("R7 noncrit drops", {30'h0, irq_crit, irq_noncrit}, 32'h2);
    chk("R8 pend next", {26'h0, pend_valid, pend_idx}, {26'h0, 1'b1, 5'd5});
    // R9 unused and read-only offsets
    wr(6, 32'hFFFF_FFFF); rd(6, v); chk("R9 masked read-only", v, 32'h0400_0000);
    wr(7, 32'hFFFF_FFFF); rd(7, v); chk("R9 offset 7", v, 32'h0);
    rd(8, v); chk("R9 offset 8", v, 32'h0);
    rd(1, v); chk("R9 offset 1", v, 32'h0);
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R5 clear all", v, 32'h0);
    settle(1); chk("R7 crit drops", {31'h0, irq_crit}, 32'h0);
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      if ($urandom % 3 == 0) src_in = src_in ^ (32'h1 << ($urandom % 32));
      if ($urandom % 6 == 0) begin
        reg_we = 1'b1; reg_addr = 4'($urandom % 16); reg_wdata = $urandom;
      end else begin
        reg_we = 1'b0;
        if ($urandom % 4 == 0) reg_addr = 4'($urandom % 16);
      end
    end
    reg_we = 1'b0;
    settle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule